// File: doc/BRIEF.md
# Demand-Priority Transmit Request Handshake

This block sits on the PHY side of a nibble-wide MII that carries a demand-priority LAN. While the MAC holds transmit enable low, the transmit nibble is not data. It is a control channel: one bit asks for a transmission and a second bit says whether the request is normal or high priority. The block keeps track of the pending request. It grants the request when the link side reports a network grant, by pulling the active-low collision line low. It then waits a fixed window for the MAC to start its frame.

Once the frame has started, the acknowledge stays low through the frame. It also stays low for a parameterised flush period after transmit enable falls, which stands for the channel work that remains. If the MAC fails to start inside the window, the block raises a one-cycle start-timeout flag and withdraws the grant. A transmit error seen during the frame is kept as a flag until the next grant.

On the receive side, the block delays the link data by two clocks. In the cycle just before receive data valid rises, it places a priority tag on the receive nibble.

Top module: `dp_txreq_hs`

## Requirements
- R1: After reset, `mii_col_n` is 1, and `start_timeout`, `frame_err`, `grant_prio`, `mii_rx_dv` and `mii_rxd` are all 0.
- R2: A request is decoded only from an edge where `mii_tx_en` is 0 and `mii_txd[0]` is 1. At such an edge `mii_txd[1]` gives the priority (0 normal, 1 high).
- R3: `mii_col_n` goes low right after the first clock edge that samples both a request (R2) and `net_grant`=1. While `net_grant` is 0, the acknowledge stays high.
- R4: While a request is held without a grant, its priority is remembered upward. If any edge during the hold saw `mii_txd[1]`=1, then `grant_prio` is 1 after the grant, even if bit 1 has since dropped to 0. `grant_prio` holds the priority of the last grant.
- R5: If `mii_tx_en` is sampled high at any of the START_WIN (default 50) edges that follow the grant edge, the frame is accepted and `mii_col_n` stays low.
- R6: If none of those START_WIN edges samples `mii_tx_en` high, then right after the last of them `mii_col_n` returns to 1 and `start_timeout` is 1 for exactly one cycle.
- R7: After the edge that first samples `mii_tx_en` low during a frame, `mii_col_n` stays low for FLUSH_CYCLES-1 more edges (default FLUSH_CYCLES is 4). It returns to 1 right after the FLUSH_CYCLES-th edge.
- R8: If `mii_tx_er` is sampled high during a frame, `frame_err` becomes 1 and stays 1 until the next grant edge clears it.
- R9: At the first edge that samples `lnk_rx_valid` high after it was low, the block registers a tag on `mii_rxd`. The tag has bit 1 equal to `lnk_rx_prio` and every other bit 0, and `mii_rx_dv` is 0 in that cycle. After the next edge `mii_rx_dv` is 1.
- R10: `mii_rxd` and `mii_rx_dv` show `lnk_rxd` and `lnk_rx_valid` two edges later. When no tag is due and no data is valid, `mii_rxd` is 0.
- R11: With `mii_tx_en` high, a nibble that has bit 0 set is not taken as a request, and no grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit/receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mii_txd | input | 4 | Transmit nibble: control when enable is low, data otherwise |
| mii_tx_en | input | 1 | Transmit enable from the MAC |
| mii_tx_er | input | 1 | Transmit error from the MAC |
| net_grant | input | 1 | Link side allows a transmission |
| mii_col_n | output | 1 | Active-low transmit acknowledge |
| grant_prio | output | 1 | Priority of the most recent grant |
| start_timeout | output | 1 | One-cycle flag: MAC missed the start window |
| frame_err | output | 1 | Sticky transmit-error flag for the current frame |
| lnk_rxd | input | 4 | Receive nibble from the link side |
| lnk_rx_valid | input | 1 | Receive data valid from the link side |
| lnk_rx_prio | input | 1 | Priority of the incoming frame |
| mii_rxd | output | 4 | Receive nibble to the MAC, carrying the tag before data |
| mii_rx_dv | output | 1 | Receive data valid to the MAC |

## Verification
The acknowledge falls one edge after a request and a grant are sampled together. The start window closes on the START_WIN-th edge after the grant, and release happens on the FLUSH_CYCLES-th edge after enable falls. The receive tag is due one edge after valid is first seen, and the data two edges after. Each bench task drives its inputs between edges and steps exactly the counted number of edges before it samples. It samples 2 ns after the edge, on both sides of every window boundary: one edge before the expected change and at the edge that makes it.

// File: rtl/dp_hs_pkg.sv
package dp_hs_pkg;
   typedef enum logic [1:0] {
      HS_IDLE  = 2'd0,
      HS_WAIT  = 2'd1,
      HS_FRAME = 2'd2,
      HS_FLUSH = 2'd3
   } hs_state_e;
endpackage

// File: rtl/dp_req_latch.sv
module dp_req_latch #(
   parameter int NIB_W       = 4,
   parameter int REQ_BIT     = 0,
   parameter int PRI_BIT     = 1,
   parameter bit PRIO_STICKY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] txd,
   input  logic             tx_en,
   input  logic             clr,
   output logic             req_now,
   output logic             prio_eff
);
   logic pend_prio_q;

   // request is only meaningful while the enable is low
   assign req_now = !tx_en && txd[REQ_BIT];

   generate
      if (PRIO_STICKY) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n || clr || !req_now) pend_prio_q <= 1'b0;
            else                           pend_prio_q <= pend_prio_q | txd[PRI_BIT];
         end
         assign prio_eff = pend_prio_q | (req_now & txd[PRI_BIT]);
      end else begin : g_follow
         always_ff @(posedge clk) pend_prio_q <= 1'b0;
         assign prio_eff = req_now & txd[PRI_BIT];
      end
   endgenerate
endmodule

// File: rtl/dp_grant_fsm.sv
module dp_grant_fsm
   import dp_hs_pkg::*;
#(
   parameter int START_WIN    = 50,
   parameter int FLUSH_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_now,
   input  logic req_prio,
   input  logic net_grant,
   input  logic tx_en,
   input  logic tx_er,
   output logic col_n,
   output logic grant_prio,
   output logic start_timeout,
   output logic frame_err,
   output logic grant_pulse
);
   localparam int CNT_MAX = (START_WIN > FLUSH_CYCLES) ? START_WIN : FLUSH_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(START_WIN - 1);
   localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_CYCLES - 1);

   generate
      if (START_WIN < 2)    begin : g_bad_win   $error("START_WIN must be at least 2");    end
      if (FLUSH_CYCLES < 1) begin : g_bad_flush $error("FLUSH_CYCLES must be at least 1"); end
   endgenerate

   hs_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;

   assign grant_pulse = (st_q == HS_IDLE) && req_now && net_grant;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q          <= HS_IDLE;
         cnt_q         <= '0;
         col_n         <= 1'b1;
         grant_prio    <= 1'b0;
         start_timeout <= 1'b0;
         frame_err     <= 1'b0;
      end else begin
         start_timeout <= 1'b0;
         unique case (st_q)
            HS_IDLE: if (grant_pulse) begin
               st_q       <= HS_WAIT;
               cnt_q      <= '0;
               col_n      <= 1'b0;
               grant_prio <= req_prio;
               frame_err  <= 1'b0;
            end
            HS_WAIT: begin
               if (tx_en) begin
                  st_q <= HS_FRAME;
               end else if (cnt_q == WIN_LAST) begin
                  st_q          <= HS_IDLE;
                  col_n         <= 1'b1;
                  start_timeout <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            HS_FRAME: begin
               if (tx_er) frame_err <= 1'b1;
               if (!tx_en) begin
                  st_q  <= HS_FLUSH;
                  cnt_q <= '0;
               end
            end
            HS_FLUSH: begin
               if (cnt_q == FLUSH_LAST) begin
                  st_q  <= HS_IDLE;
                  col_n <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= HS_IDLE;
         endcase
      end
   end

   // R3: acknowledge falls only after a request edge that also saw the network grant
   assert_grant_needs_net_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(col_n) |-> ($past(net_grant) && $past(req_now)));
   // R6: the timeout flag coincides with release of the acknowledge
   assert_timeout_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_timeout |-> (col_n && $past(!col_n) && $past(!tx_en)));
   // R6: the timeout flag lasts one cycle
   assert_timeout_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start_timeout |=> !start_timeout);
   // R8: the error flag rises only from a sampled transmit error under a grant
   assert_err_from_txer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err) |-> ($past(tx_er) && $past(!col_n)));
   // R7: a normal release happens only with the enable low
   assert_release_enable_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(col_n) && !start_timeout) |-> $past(!tx_en));
endmodule

// File: rtl/dp_rx_tagger.sv
module dp_rx_tagger #(
   parameter int NIB_W   = 4,
   parameter int PRI_BIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] lnk_rxd,
   input  logic             lnk_rx_valid,
   input  logic             lnk_rx_prio,
   output logic [NIB_W-1:0] mii_rxd,
   output logic             mii_rx_dv
);
   logic             valid_q;
   logic [NIB_W-1:0] data_q;
   logic [NIB_W-1:0] tag;
   logic             frame_start;

   assign frame_start = lnk_rx_valid && !valid_q;

   always_comb begin
      tag          = '0;
      tag[PRI_BIT] = lnk_rx_prio;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         data_q    <= '0;
         mii_rxd   <= '0;
         mii_rx_dv <= 1'b0;
      end else begin
         valid_q   <= lnk_rx_valid;
         data_q    <= lnk_rx_valid ? lnk_rxd : '0;
         mii_rx_dv <= valid_q;
         if (frame_start)  mii_rxd <= tag;
         else if (valid_q) mii_rxd <= data_q;
         else              mii_rxd <= '0;
      end
   end

   // R9: the cycle before valid rises carries the frame priority
   assert_tag_before_dv_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_rx_dv) |-> ($past(mii_rxd[PRI_BIT]) == $past(lnk_rx_prio, 2)));
   // R10: receive valid follows the link valid by two edges
   assert_dv_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mii_rx_dv) |-> $past(lnk_rx_valid, 2));
endmodule

// File: rtl/dp_txreq_hs.sv
module dp_txreq_hs #(
   parameter int NIB_W        = 4,
   parameter int START_WIN    = 50,
   parameter int FLUSH_CYCLES = 4,
   parameter bit PRIO_STICKY  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIB_W-1:0] mii_txd,
   input  logic             mii_tx_en,
   input  logic             mii_tx_er,
   input  logic             net_grant,
   output logic             mii_col_n,
   output logic             grant_prio,
   output logic             start_timeout,
   output logic             frame_err,
   input  logic [NIB_W-1:0] lnk_rxd,
   input  logic             lnk_rx_valid,
   input  logic             lnk_rx_prio,
   output logic [NIB_W-1:0] mii_rxd,
   output logic             mii_rx_dv
);
   localparam int REQ_BIT = 0;
   localparam int PRI_BIT = 1;

   generate
      if (NIB_W < 2) begin : g_bad_nib $error("NIB_W must hold request and priority bits"); end
   endgenerate

   logic req_now, prio_eff, grant_pulse;

   dp_req_latch #(
      .NIB_W(NIB_W), .REQ_BIT(REQ_BIT), .PRI_BIT(PRI_BIT), .PRIO_STICKY(PRIO_STICKY)
   ) u_req (
      .clk(clk), .rst_n(rst_n), .txd(mii_txd), .tx_en(mii_tx_en),
      .clr(grant_pulse), .req_now(req_now), .prio_eff(prio_eff)
   );

   dp_grant_fsm #(.START_WIN(START_WIN), .FLUSH_CYCLES(FLUSH_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_now(req_now), .req_prio(prio_eff),
      .net_grant(net_grant), .tx_en(mii_tx_en), .tx_er(mii_tx_er),
      .col_n(mii_col_n), .grant_prio(grant_prio), .start_timeout(start_timeout),
      .frame_err(frame_err), .grant_pulse(grant_pulse)
   );

   dp_rx_tagger #(.NIB_W(NIB_W), .PRI_BIT(PRI_BIT)) u_rx (
      .clk(clk), .rst_n(rst_n), .lnk_rxd(lnk_rxd), .lnk_rx_valid(lnk_rx_valid),
      .lnk_rx_prio(lnk_rx_prio), .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv)
   );

   // R11: a nibble seen with enable high never produces a grant
   assert_no_grant_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mii_col_n) |-> $past(!mii_tx_en));
endmodule

// File: tb/dp_txreq_hs_bench.sv
`timescale 1ns/1ps
module dp_txreq_hs_bench;
   localparam int WIN   = 50;
   localparam int FLUSH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mii_txd = '0;
   logic       mii_tx_en = 1'b0, mii_tx_er = 1'b0, net_grant = 1'b0;
   logic       mii_col_n, grant_prio, start_timeout, frame_err;
   logic [3:0] lnk_rxd = '0;
   logic       lnk_rx_valid = 1'b0, lnk_rx_prio = 1'b0;
   logic [3:0] mii_rxd;
   logic       mii_rx_dv;
   int         n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   dp_txreq_hs #(.START_WIN(WIN), .FLUSH_CYCLES(FLUSH)) u_dp_txreq_hs (
      .clk(clk), .rst_n(rst_n), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
      .mii_tx_er(mii_tx_er), .net_grant(net_grant), .mii_col_n(mii_col_n),
      .grant_prio(grant_prio), .start_timeout(start_timeout), .frame_err(frame_err),
      .lnk_rxd(lnk_rxd), .lnk_rx_valid(lnk_rx_valid), .lnk_rx_prio(lnk_rx_prio),
      .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // grant a request of given priority; returns just after the grant edge
   task automatic do_grant(input logic prio);
      mii_txd   = {2'b00, prio, 1'b1};
      net_grant = 1'b1;
      step();
      mii_txd   = '0;
      net_grant = 1'b0;
   endtask

   task automatic t_reset;
      chk(mii_col_n, 1, "R1 col_n");
      chk(start_timeout, 0, "R1 timeout");
      chk(frame_err, 0, "R1 frame_err");
      chk(grant_prio, 0, "R1 grant_prio");
      chk(mii_rx_dv, 0, "R1 rx_dv");
      chk(mii_rxd, 0, "R1 rxd");
   endtask

   task automatic t_no_net_grant;
      mii_txd = 4'b0001;
      step(3);
      chk(mii_col_n, 1, "R3 held without net grant");
      net_grant = 1'b1;
      step();
      chk(mii_col_n, 0, "R3 granted on joint edge");
      chk(grant_prio, 0, "R2 normal priority decoded");
      mii_txd = '0;
      net_grant = 1'b0;
      step(WIN);   // let it time out
      chk(mii_col_n, 1, "R6 released after window");
      step();
   endtask

   task automatic t_frame_ok;
      do_grant(1'b1);
      chk(mii_col_n, 0, "R3 ack low");
      chk(grant_prio, 1, "R2 high priority decoded");
      step(WIN - 1);
      chk(mii_col_n, 0, "R5 still granted before last window edge");
      mii_tx_en = 1'b1;
      mii_txd = 4'b1010;
      step();      // last window edge samples enable
      chk(mii_col_n, 0, "R5 start on last edge accepted");
      chk(start_timeout, 0, "R5 no timeout");
      mii_tx_er = 1'b1;
      step();
      mii_tx_er = 1'b0;
      step(2);
      chk(frame_err, 1, "R8 error sticky in frame");
      mii_tx_en = 1'b0;
      mii_txd = '0;
      step();      // enable-low edge
      step(FLUSH - 1);
      chk(mii_col_n, 0, "R7 held during flush");
      step();
      chk(mii_col_n, 1, "R7 released after flush");
      chk(frame_err, 1, "R8 error kept after frame");
      step(2);
      do_grant(1'b0);
      chk(frame_err, 0, "R8 cleared by next grant");
      step(WIN + 1);
   endtask

   task automatic t_timeout;
      do_grant(1'b0);
      step(WIN - 1);
      chk(mii_col_n, 0, "R6 held one edge before expiry");
      chk(start_timeout, 0, "R6 no early timeout");
      step();
      chk(mii_col_n, 1, "R6 released at expiry");
      chk(start_timeout, 1, "R6 timeout flagged");
      step();
      chk(start_timeout, 0, "R6 timeout one cycle");
   endtask

   task automatic t_prio_pref;
      mii_txd = 4'b0001;
      step(2);
      mii_txd = 4'b0011;
      step();
      mii_txd = 4'b0001;
      step(2);
      chk(mii_col_n, 1, "R4 no grant yet");
      net_grant = 1'b1;
      step();
      chk(mii_col_n, 0, "R4 granted");
      chk(grant_prio, 1, "R4 high priority kept");
      mii_txd = '0;
      net_grant = 1'b0;
      step(WIN + 1);
   endtask

   task automatic t_ignore_en;
      mii_tx_en = 1'b1;
      mii_txd = 4'b0011;
      net_grant = 1'b1;
      step(4);
      chk(mii_col_n, 1, "R11 request ignored with enable high");
      mii_tx_en = 1'b0;
      mii_txd = '0;
      net_grant = 1'b0;
      step();
   endtask

   task automatic t_rx(input logic prio);
      lnk_rx_valid = 1'b1;
      lnk_rx_prio = prio;
      lnk_rxd = 4'hA;
      step();
      chk(mii_rxd, {2'b00, prio, 1'b0}, "R9 tag nibble");
      chk(mii_rx_dv, 0, "R9 dv low during tag");
      lnk_rxd = 4'h5;
      lnk_rx_prio = ~prio;
      step();
      chk(mii_rx_dv, 1, "R9 dv rises after tag");
      chk(mii_rxd, 4'hA, "R10 first data");
      lnk_rx_valid = 1'b0;
      lnk_rxd = 4'hF;
      step();
      chk(mii_rxd, 4'h5, "R10 second data");
      chk(mii_rx_dv, 1, "R10 dv held");
      step();
      chk(mii_rx_dv, 0, "R10 dv falls");
      chk(mii_rxd, 0, "R10 idle nibble zero");
   endtask

   initial begin
      step(3);
      t_reset();
      rst_n = 1'b1;
      step();
      t_no_net_grant();
      t_frame_ok();
      t_timeout();
      t_prio_pref();
      t_ignore_en();
      t_rx(1'b1);
      t_rx(1'b0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule